// File: doc/BRIEF.md
# Exception Entry Sequencer

This block performs the state update a 32-bit RISC core with branch delay slots needs when it takes an exception. The pipeline presents a cause code and a one-cycle valid strobe. With them it presents a flag telling whether the faulting instruction sits in a delay slot, the current, next and branch-target program counters, and the live status register. One clock later the block returns a committed result: the saved exception PC, the saved status word, the new supervisor-mode status word and the vector address. The same edge produces single-cycle pulses for the commit, a TLB flush and the clearing of the delay-slot flag.

The saved PC depends on two things. One is whether the instruction was in a delay slot. The other is whether the cause is a resume-after class (timer tick, external interrupt, system call, floating-point) or a re-execute class (every other cause). A cause code outside the legal range raises an abort pulse and leaves the vector output holding its previous value.

Top module: `exc_entry`

## Requirements
- R1: Outside a delay slot, causes 5 (tick), 8 (interrupt), 12 (system call) and 13 (floating point) save the next PC as the exception PC. Every other cause saves the current PC.
- R2: Inside a delay slot, those same four causes save the branch-target PC. Every other cause saves the current PC minus 4.
- R3: The saved status word equals the incoming status register. When the instruction is in a delay slot, bit 13 (delay-slot exception) is also set in it.
- R4: The new status word equals the saved status word with bits 1 (tick enable), 2 (interrupt enable), 5 (data MMU enable) and 6 (instruction MMU enable) cleared and bit 0 (supervisor) set. All other bits pass through unchanged.
- R5: For a cause in the range 1 to 14, the new PC is the cause shifted left by 8, which places the vectors 256 bytes apart.
- R6: A cause of 0 or of 15 and above produces a one-cycle abort pulse, and the new PC output keeps its previous value.
- R7: The commit and TLB-flush outputs pulse for exactly the one cycle after each valid strobe. They stay low when no strobe was presented.
- R8: The delay-slot-clear output pulses together with commit when the entry came from a delay slot, and stays low otherwise.
- R9: After reset every output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| exc_valid | input | 1 | Take an exception this cycle |
| exc_cause | input | 5 | Cause code |
| in_dslot | input | 1 | Faulting instruction is in a delay slot |
| pc_cur | input | 32 | PC of the faulting instruction |
| pc_nxt | input | 32 | Sequential next PC |
| pc_tgt | input | 32 | Pending branch target |
| sr_in | input | 32 | Live status register |
| commit | output | 1 | Entry committed (pulse) |
| epc_out | output | 32 | Saved exception PC |
| esr_out | output | 32 | Saved status word |
| sr_out | output | 32 | New status word |
| pc_out | output | 32 | Vector address |
| tlb_flush | output | 1 | TLB flush request (pulse) |
| abort | output | 1 | Illegal cause (pulse) |
| dslot_clr | output | 1 | Clear the pipeline delay-slot flag (pulse) |

## Verification
The bench sweeps every 5-bit cause code, with and without the delay-slot flag, across several status patterns. This covers both ends of the legal range (0, 1, 14, 15 and 31) and every member of the resume class. A design that classified a cause wrongly would save the current PC where the next or target PC is due, or drop the minus-4 correction in a delay slot. A design that took DSX into the saved word after the copy instead of before would lose it from the saved status word. Between strobes the bench checks that no pulse repeats. After each illegal cause it checks that the vector still holds the last legal value, so a design that loaded the shifted illegal code would be caught.

// File: rtl/exc_entry.sv
module exc_entry #(
  parameter int XLEN      = 32,
  parameter int CW        = 5,
  parameter int NCAUSE    = 15,
  parameter int VEC_SHIFT = 8,
  parameter int B_SM      = 0,
  parameter int B_TEE     = 1,
  parameter int B_IEE     = 2,
  parameter int B_DME     = 5,
  parameter int B_IME     = 6,
  parameter int B_DSX     = 13,
  parameter int C_TICK    = 5,
  parameter int C_INT     = 8,
  parameter int C_SYSC    = 12,
  parameter int C_FPE     = 13
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            exc_valid,
  input  logic [CW-1:0]   exc_cause,
  input  logic            in_dslot,
  input  logic [XLEN-1:0] pc_cur,
  input  logic [XLEN-1:0] pc_nxt,
  input  logic [XLEN-1:0] pc_tgt,
  input  logic [XLEN-1:0] sr_in,
  output logic            commit,
  output logic [XLEN-1:0] epc_out,
  output logic [XLEN-1:0] esr_out,
  output logic [XLEN-1:0] sr_out,
  output logic [XLEN-1:0] pc_out,
  output logic            tlb_flush,
  output logic            abort,
  output logic            dslot_clr
);

  localparam logic [XLEN-1:0] INSN_BYTES = XLEN'(4);
  localparam logic [XLEN-1:0] DSX_BIT    = XLEN'(1) << B_DSX;
  localparam logic [XLEN-1:0] SM_BIT     = XLEN'(1) << B_SM;
  localparam logic [XLEN-1:0] CLR_MASK   = (XLEN'(1) << B_TEE) | (XLEN'(1) << B_IEE)
                                         | (XLEN'(1) << B_DME) | (XLEN'(1) << B_IME);

  logic            resume_cls;
  logic            legal;
  logic [XLEN-1:0] epc_d, esr_d, sr_d, vec_d;

  assign resume_cls = (exc_cause == CW'(C_TICK)) || (exc_cause == CW'(C_INT)) ||
                      (exc_cause == CW'(C_SYSC)) || (exc_cause == CW'(C_FPE));
  assign legal      = (exc_cause != '0) && (exc_cause < CW'(NCAUSE));

  assign epc_d = in_dslot ? (resume_cls ? pc_tgt : pc_cur - INSN_BYTES)
                          : (resume_cls ? pc_nxt : pc_cur);
  assign esr_d = in_dslot ? (sr_in | DSX_BIT) : sr_in;
  assign sr_d  = (esr_d & ~CLR_MASK) | SM_BIT;
  assign vec_d = {{(XLEN-CW){1'b0}}, exc_cause} << VEC_SHIFT;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      commit    <= 1'b0;
      tlb_flush <= 1'b0;
      abort     <= 1'b0;
      dslot_clr <= 1'b0;
      epc_out   <= '0;
      esr_out   <= '0;
      sr_out    <= '0;
      pc_out    <= '0;
    end else begin
      commit    <= exc_valid;
      tlb_flush <= exc_valid;
      abort     <= exc_valid && !legal;
      dslot_clr <= exc_valid && in_dslot;
      if (exc_valid) begin
        epc_out <= epc_d;
        esr_out <= esr_d;
        sr_out  <= sr_d;
        if (legal) pc_out <= vec_d;
      end
    end
  end

  assert_pulse_after_valid_R7: assert property (@(posedge clk) disable iff (!rst_n)
    exc_valid |=> (commit && tlb_flush));
  assert_no_pulse_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !exc_valid |=> (!commit && !tlb_flush && !abort && !dslot_clr));
  assert_abort_holds_pc_R6: assert property (@(posedge clk) disable iff (!rst_n)
    abort |-> $stable(pc_out));
  assert_supervisor_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
    commit |-> (sr_out[B_SM] && !sr_out[B_TEE] && !sr_out[B_IEE] && !sr_out[B_DME] && !sr_out[B_IME]));
  assert_dsx_saved_R3: assert property (@(posedge clk) disable iff (!rst_n)
    dslot_clr |-> (esr_out[B_DSX] && sr_out[B_DSX]));
  assert_vector_aligned_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && !abort) |-> (pc_out[VEC_SHIFT-1:0] == '0 && pc_out != '0));
  assert_pulse_only_with_commit_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (abort || dslot_clr) |-> commit);

endmodule

// File: tb/exc_entry_tb_top.sv
`timescale 1ns/1ps
module exc_entry_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        exc_valid = 1'b0;
  logic [4:0]  exc_cause = '0;
  logic        in_dslot = 1'b0;
  logic [31:0] pc_cur = '0, pc_nxt = '0, pc_tgt = '0, sr_in = '0;
  logic        commit, tlb_flush, abort, dslot_clr;
  logic [31:0] epc_out, esr_out, sr_out, pc_out;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  exc_entry dut_i (
    .clk(clk), .rst_n(rst_n), .exc_valid(exc_valid), .exc_cause(exc_cause),
    .in_dslot(in_dslot), .pc_cur(pc_cur), .pc_nxt(pc_nxt), .pc_tgt(pc_tgt),
    .sr_in(sr_in), .commit(commit), .epc_out(epc_out), .esr_out(esr_out),
    .sr_out(sr_out), .pc_out(pc_out), .tlb_flush(tlb_flush), .abort(abort),
    .dslot_clr(dslot_clr)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  initial begin
    logic [31:0] pc_model;
    logic [31:0] srs [4];
    srs[0] = 32'hFFFF_FFFF; srs[1] = 32'h0000_0000;
    srs[2] = 32'hA5A5_5A5A; srs[3] = 32'h0000_0066;
    pc_model = '0;
    repeat (3) @(negedge clk);
    // R9: reset state
    chk("R9 commit", {31'd0, commit}, 32'd0);
    chk("R9 flush", {31'd0, tlb_flush}, 32'd0);
    chk("R9 abort", {31'd0, abort}, 32'd0);
    chk("R9 epc", epc_out, 32'd0);
    chk("R9 sr", sr_out, 32'd0);
    chk("R9 pc", pc_out, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    for (int s = 0; s < 4; s++) begin
      for (int ds = 0; ds < 2; ds++) begin
        for (int c = 0; c < 32; c++) begin
          logic resume, legal;
          logic [31:0] e_epc, e_esr, e_sr;
          exc_valid = 1'b1;
          exc_cause = 5'(c);
          in_dslot  = ds[0];
          pc_cur    = 32'h0001_0000 + 32'(c) * 32'h40 + 32'(s) * 32'h1000;
          pc_nxt    = pc_cur + 32'd4;
          pc_tgt    = 32'h0800_0000 ^ (32'(c) << 4) ^ 32'(s << 12);
          sr_in     = srs[s];
          resume = (c == 5) || (c == 8) || (c == 12) || (c == 13);
          legal  = (c > 0) && (c < 15);
          if (ds != 0) e_epc = resume ? pc_tgt : pc_cur - 32'd4;
          else         e_epc = resume ? pc_nxt : pc_cur;
          e_esr = (ds != 0) ? (sr_in | 32'h0000_2000) : sr_in;
          e_sr  = (e_esr & ~32'h0000_0066) | 32'h1;
          if (legal) pc_model = 32'(c) << 8;
          @(negedge clk);
          exc_valid = 1'b0;
          if (ds != 0) chk("R2 epc", epc_out, e_epc);
          else         chk("R1 epc", epc_out, e_epc);
          chk("R3 esr", esr_out, e_esr);
          chk("R4 sr", sr_out, e_sr);
          if (legal) chk("R5 pc", pc_out, pc_model);
          else       chk("R6 pc hold", pc_out, pc_model);
          chk("R6 abort", {31'd0, abort}, {31'd0, !legal});
          chk("R7 commit", {31'd0, commit}, 32'd1);
          chk("R7 flush", {31'd0, tlb_flush}, 32'd1);
          chk("R8 dslot_clr", {31'd0, dslot_clr}, 32'(ds));
          if (c % 8 == 7) begin
            @(negedge clk);
            chk("R7 idle commit", {31'd0, commit}, 32'd0);
            chk("R7 idle flush", {31'd0, tlb_flush}, 32'd0);
            chk("R8 idle dslot_clr", {31'd0, dslot_clr}, 32'd0);
            chk("R6 idle pc", pc_out, pc_model);
          end
        end
      end
    end
    @(negedge clk);
    chk("R7 final idle", {30'd0, commit, tlb_flush}, 32'd0);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule